// File: doc/BRIEF.md
# Quad DAC Double-Buffered Register Interface

This block is the register front end of a four-channel, 12-bit digital-to-analog converter. It sits on a processor's parallel I/O bus and takes an address, a data word, a write strobe and an I/O-space select as inputs. Each channel has two registers. The first is a staging register that software loads. The second is an output register that drives the converter's data inputs.

Writing a channel's address changes only its staging register. A write to the single address just above the four channel addresses is the commit. It copies every staging value into the output registers on the same clock edge, so all four analog outputs move together. Software can load any subset of channels, in any order, and release them with one commit. A read cycle inside the window returns the staged value of the addressed channel. The window starts at a base address that is a parameter and is zero by default.

Top module: `dac_quad_stage`

## Requirements
- R1: With `ioSel` and `ioWr` both high, a write to offset k (0 to 3) from the base stores `ioWrData[11:0]` in the staging register of channel k+1. Channel k+1 always drives `dacCode[12k+11:12k]`, so offset 0 is channel 1 in the lowest 12 bits.
- R2: A write to a staging register leaves `dacCode` unchanged.
- R3: A write to offset 4 copies all four staging values into the output registers on that clock edge. The new values appear on `dacCode` right after that edge.
- R4: The data word presented with a commit write is ignored, and a commit does not alter any staging register.
- R5: Bits 15:12 of a write are discarded, and bits 15:12 of `ioRdData` are always zero.
- R6: While `rst_n` is low, every staging and output register is held at zero.
- R7: No register changes unless `ioSel` and `ioWr` are both high and the address lies between offset 0 and offset 4. This covers writes with the select low, read cycles, and addresses at offset 5 or above.
- R8: With `ioSel` high and `ioWr` low, `ioRdData` shows the staged value of channel k+1 for offset k (0 to 3) in the same cycle. It shows zero at offset 4, at addresses outside the window, and whenever `ioSel` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ioSel | input | 1 | I/O-space select, active high |
| ioWr | input | 1 | Write strobe, active high |
| ioAddr | input | 16 | I/O address |
| ioWrData | input | 16 | Write data |
| ioRdData | output | 16 | Readback of the staged value of the addressed channel |
| dacCode | output | 48 | Four 12-bit output codes, channel 1 in bits 11:0 |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 16-bit data bus, 12-bit codes and a base address of zero. The data bus is four bits wider than a code, which makes the discard of the upper write bits and the zero readback bits observable. The base of zero puts the addresses just past the window, offsets 5 and 0x10, within reach, and confirms they are ignored. The scoreboard predicts `dacCode` after every bus cycle. This exposes any output that moves on a staging write, any commit that misses a channel, and any write that lands outside its intended condition.

// File: rtl/dacq_pkg.sv
package dacq_pkg;
  localparam int DAC_CH = 4;
  localparam int IDX_W  = $clog2(DAC_CH);

  typedef struct packed {
    logic [DAC_CH-1:0] holdWe;
    logic              commit;
    logic              rdValid;
    logic [IDX_W-1:0]  rdIdx;
  } dacq_strobe_t;
endpackage

// File: rtl/dacq_ctrl.sv
module dacq_ctrl
  import dacq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              ioSel,
  input  logic              ioWr,
  input  logic [ADDR_W-1:0] ioAddr,
  output dacq_strobe_t      strb
);
  localparam logic [ADDR_W-1:0] XFER_OFS = ADDR_W'(DAC_CH);

  logic [ADDR_W-1:0] offset;
  logic              inWindow;
  logic              wrAct;
  logic [DAC_CH-1:0] holdHit;

  assign offset   = ioAddr - BASE_ADDR;
  assign inWindow = (ioAddr >= BASE_ADDR) && (offset <= XFER_OFS);
  assign wrAct    = ioSel && ioWr && inWindow;

  // One-hot staging write enable, one decode per channel
  for (genvar k = 0; k < DAC_CH; k++) begin : g_hit
    assign holdHit[k] = wrAct && (offset == ADDR_W'(k));
  end

  always_comb begin
    strb.holdWe  = holdHit;
    strb.commit  = wrAct && (offset == XFER_OFS);
    strb.rdValid = ioSel && !ioWr && inWindow && (offset < XFER_OFS);
    strb.rdIdx   = offset[IDX_W-1:0];
  end
endmodule

// File: rtl/dacq_datapath.sv
module dacq_datapath
  import dacq_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int CH_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  dacq_strobe_t             strb,
  input  logic [BUS_W-1:0]         wrData,
  output logic [DAC_CH*CH_W-1:0]   holdFlat,
  output logic [DAC_CH*CH_W-1:0]   dacCode,
  output logic [BUS_W-1:0]         rdData
);
  logic [CH_W-1:0] holdReg [DAC_CH];
  logic [CH_W-1:0] outReg  [DAC_CH];
  logic            unusedHiBits;

  assign unusedHiBits = ^wrData[BUS_W-1:CH_W];

  for (genvar ch = 0; ch < DAC_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                holdReg[ch] <= '0;
      else if (strb.holdWe[ch])  holdReg[ch] <= wrData[CH_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           outReg[ch] <= '0;
      else if (strb.commit) outReg[ch] <= holdReg[ch];
    end

    assign holdFlat[ch*CH_W +: CH_W] = holdReg[ch];
    assign dacCode[ch*CH_W +: CH_W]  = outReg[ch];
  end

  always_comb begin
    rdData = '0;
    if (strb.rdValid) rdData[CH_W-1:0] = holdReg[strb.rdIdx];
  end
endmodule

// File: rtl/dac_quad_stage.sv
module dac_quad_stage
  import dacq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16,
  parameter int CH_W   = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ioSel,
  input  logic                   ioWr,
  input  logic [ADDR_W-1:0]      ioAddr,
  input  logic [BUS_W-1:0]       ioWrData,
  output logic [BUS_W-1:0]       ioRdData,
  output logic [DAC_CH*CH_W-1:0] dacCode
);
  dacq_strobe_t            strb;
  logic [DAC_CH*CH_W-1:0]  holdFlat;

  dacq_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .ioSel (ioSel),
    .ioWr  (ioWr),
    .ioAddr(ioAddr),
    .strb  (strb)
  );

  dacq_datapath #(.BUS_W(BUS_W), .CH_W(CH_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wrData  (ioWrData),
    .holdFlat(holdFlat),
    .dacCode (dacCode),
    .rdData  (ioRdData)
  );
endmodule

// File: rtl/dacq_checker.sv
module dacq_checker
  import dacq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BUS_W  = 16,
  parameter int CH_W   = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ioSel,
  input logic                   ioWr,
  input logic [ADDR_W-1:0]      ioAddr,
  input logic [BUS_W-1:0]       ioWrData,
  input logic [BUS_W-1:0]       ioRdData,
  input logic [DAC_CH*CH_W-1:0] dacCode,
  input logic [DAC_CH*CH_W-1:0] holdFlat
);
  localparam logic [ADDR_W-1:0] XFER_OFS = ADDR_W'(DAC_CH);

  logic [ADDR_W-1:0] ofs;
  logic inWin, wrCyc, isCommit, isHold;

  assign ofs      = ioAddr - BASE_ADDR;
  assign inWin    = (ioAddr >= BASE_ADDR) && (ofs <= XFER_OFS);
  assign wrCyc    = ioSel && ioWr && inWin;
  assign isCommit = wrCyc && (ofs == XFER_OFS);
  assign isHold   = wrCyc && (ofs < XFER_OFS);

  // R1: addressed staging register takes the low data bits
  for (genvar k = 0; k < DAC_CH; k++) begin : g_ld
    a_r1_hold_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wrCyc && ofs == ADDR_W'(k)) |=> holdFlat[k*CH_W +: CH_W] == $past(ioWrData[CH_W-1:0]));
  end

  a_r2_hold_keeps_out: assert property (@(posedge clk) disable iff (!rst_n)
    isHold |=> $stable(dacCode));

  a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
    isCommit |=> dacCode == $past(holdFlat));

  a_r4_commit_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    isCommit |=> $stable(holdFlat));

  a_r5_rd_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ioRdData[BUS_W-1:CH_W] == '0);

  a_r7_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !wrCyc |=> ($stable(dacCode) && $stable(holdFlat)));

  a_r8_rd_deselect_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !ioSel |-> ioRdData == '0);
endmodule

bind dac_quad_stage dacq_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CH_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ioSel   (ioSel),
  .ioWr    (ioWr),
  .ioAddr  (ioAddr),
  .ioWrData(ioWrData),
  .ioRdData(ioRdData),
  .dacCode (dacCode),
  .holdFlat(holdFlat)
);

// File: tb/tb_dac_quad_stage.sv
module tb_dac_quad_stage;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ioSel = 1'b0;
  logic        ioWr = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [15:0] ioWrData = '0;
  logic [15:0] ioRdData;
  logic [47:0] dacCode;

  always #10 clk = ~clk;

  dac_quad_stage dut (
    .clk(clk), .rst_n(rst_n), .ioSel(ioSel), .ioWr(ioWr),
    .ioAddr(ioAddr), .ioWrData(ioWrData),
    .ioRdData(ioRdData), .dacCode(dacCode)
  );

  typedef struct {
    logic [47:0] exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;
  logic [11:0] holdM [4];
  logic [11:0] outM  [4];

  function automatic logic [47:0] packOut();
    logic [47:0] v;
    for (int c = 0; c < 4; c++) v[c*12 +: 12] = outM[c];
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Monitor: pops one prediction per bus write, after the edge has settled
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        check(dacCode === it.exp, it.tag, dacCode, it.exp);
      end
    end
  end

  // Driver: one bus cycle, model update, prediction pushed
  task automatic busWrite(bit sel, bit wr, logic [15:0] addr, logic [15:0] data, string tag);
    @(negedge clk);
    ioSel = sel; ioWr = wr; ioAddr = addr; ioWrData = data;
    if (sel && wr && addr <= 16'd4) begin
      if (addr < 16'd4) holdM[addr[1:0]] = data[11:0];
      else for (int c = 0; c < 4; c++) outM[c] = holdM[c];
    end
    sbq.push_back('{packOut(), tag});
  endtask

  task automatic busRead(logic [15:0] addr, string tag);
    logic [15:0] exp;
    @(negedge clk);
    ioSel = 1'b1; ioWr = 1'b0; ioAddr = addr; ioWrData = 16'hFFFF;
    #1;
    exp = (addr < 16'd4) ? {4'h0, holdM[addr[1:0]]} : 16'h0000;
    check(ioRdData === exp, tag, 48'(ioRdData), 48'(exp));
  endtask

  task automatic readAll(string tag);
    for (int a = 0; a < 4; a++) busRead(16'(a), tag);
  endtask

  task automatic idle();
    @(negedge clk);
    ioSel = 1'b0; ioWr = 1'b0; ioAddr = '0; ioWrData = '0;
    #1;
    check(ioRdData === 16'h0, "R8 deselected readback", 48'(ioRdData), 48'h0);
  endtask

  task automatic clearModel();
    for (int c = 0; c < 4; c++) begin holdM[c] = '0; outM[c] = '0; end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    #1;
    check(dacCode === 48'h0, "R6 outputs during reset", dacCode, 48'h0);
    @(negedge clk);
    rst_n = 1'b1;
    readAll("R6 staging zero after reset");

    // Stage all four with junk in the upper bits: outputs must hold
    busWrite(1, 1, 16'h0000, 16'hF123, "R2 stage ch1 output held");
    busWrite(1, 1, 16'h0001, 16'h0456, "R2 stage ch2 output held");
    busWrite(1, 1, 16'h0002, 16'hA789, "R2 stage ch3 output held");
    busWrite(1, 1, 16'h0003, 16'h5ABC, "R2 stage ch4 output held");
    readAll("R1 R5 staged readback low bits");

    // Commit with a nonzero data word
    busWrite(1, 1, 16'h0004, 16'hFFFF, "R3 commit moves all channels");
    readAll("R4 staging untouched by commit");
    busRead(16'h0004, "R8 readback at commit offset is zero");

    // Update a single channel
    busWrite(1, 1, 16'h0001, 16'h0111, "R2 single stage output held");
    busWrite(1, 1, 16'h0004, 16'h0000, "R3 commit single change");

    // Ignored traffic
    busWrite(0, 1, 16'h0000, 16'h0DEA, "R7 write without select");
    busWrite(1, 0, 16'h0002, 16'h0BAD, "R7 read cycle no write");
    busWrite(1, 1, 16'h0002, 16'h0777, "R2 stage ch3 before ignored commit");
    busWrite(1, 0, 16'h0004, 16'h0000, "R7 read at commit offset no commit");
    busWrite(0, 1, 16'h0004, 16'h0000, "R7 commit without select");
    busWrite(1, 1, 16'h0005, 16'h0FFF, "R7 offset five ignored");
    busWrite(1, 1, 16'h0010, 16'h0EEE, "R7 far address ignored");
    busRead(16'h0005, "R8 readback outside window");
    readAll("R7 staging after ignored traffic");
    idle();
    busWrite(1, 1, 16'h0004, 16'h1234, "R3 R4 commit staged ch3");

    // Pattern sweep, alternating write order
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 4; j++) begin
        int c;
        c = (i % 2 == 0) ? j : 3 - j;
        busWrite(1, 1, 16'(c), 16'(i * 16'h0931 + c * 16'h1357 + 16'h8000),
                 "R1 R2 sweep stage");
      end
      busWrite(1, 1, 16'h0004, 16'(i * 16'h3C3C), "R3 sweep commit");
      if (i % 4 == 0) readAll("R1 R5 sweep readback");
    end

    // Reset in mid-run clears both register sets
    @(negedge clk);
    rst_n = 1'b0;
    clearModel();
    #1;
    check(dacCode === 48'h0, "R6 mid-run reset outputs", dacCode, 48'h0);
    @(negedge clk);
    rst_n = 1'b1;
    readAll("R6 mid-run reset staging");
    idle();
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule